// File: doc/BRIEF.md
# Up-Counting Time Base with Buffered Divider and Period

A 16-bit time base that counts upward at a rate set by a programmable clock divider and wraps at a programmable period. Each wrap produces an update event. Software can also request an update event directly. The event does three things. It copies the written divider value into the active divider. It can copy the written period value into the active period. It can set a sticky status flag.

Software controls the block through a small register port. The port has a write strobe, a 3-bit address, write data and combinational read data. There are three outputs:
- a one-cycle update pulse, meant to trigger an external converter,
- a level interrupt,
- a one-cycle DMA request.

Two controls shape the update event. An update-disable bit suppresses the event. A request-source bit decides whether a software request sets the flag.

Register addresses: 0 control, 1 enables, 2 status, 3 event request, 4 count, 5 divider, 6 period. Addresses 3 and 7 read as 0.

Top module: `upcount_tbase`

## Requirements
- R1: After reset, the following hold.
  - Count (addr 4) and divider (addr 5) read 0.
  - Period (addr 6) reads 0xFFFF, and the active period is also 0xFFFF.
  - Control (addr 0), enables (addr 1) and status (addr 2) read 0.
  - uev_o, irq_o and dma_o are 0.
- R2: The count advances only while control bit 0 (run) is 1. With active divider D, it advances by one every D+1 clocks.
- R3: On an advance, if the count has reached or passed the active period, the count returns to 0 and an overflow occurs. Otherwise the count increments. The update event shows as uev_o high for exactly the one cycle after the clock edge that wraps the count.
- R4: A write to the divider (addr 5) changes the active divider only at the next update event.
- R5: Control bit 7 selects how a period write (addr 6) takes effect.
  - When bit 7 is 0, the written period is active from the next cycle.
  - When bit 7 is 1, it becomes active only at the next update event.
- R6: While control bit 1 (update disable) is 1, the following hold.
  - No update event is produced: uev_o stays 0, the flag is not set and the active divider and period are kept.
  - An event request still clears the count and the divider phase.
- R7: Control bit 2 selects which update events set the flag.
  - When bit 2 is 0, both overflow and event request set the status flag.
  - When bit 2 is 1, only overflow sets it.
- R8: Writing 1 to bit 0 of address 3 clears the count and the divider phase. Unless updates are disabled, it also produces an update event. Address 3 always reads 0.
- R9: Status bit 0 is set by the block. A write of 0 to it clears it, and a write of 1 has no effect. A set in the same cycle as a clearing write wins.
- R10: irq_o is the flag ANDed with enable bit 0. dma_o pulses for one cycle on each flag-setting event while enable bit 1 is 1.
- R11: While the active period is 0, the count does not advance and no overflow occurs.
- R12: A write to the count (addr 4) loads it directly. The write overrides any advance or overflow in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| uev_o | output | 1 | One-cycle update event pulse |
| irq_o | output | 1 | Interrupt level |
| dma_o | output | 1 | One-cycle DMA request |

## Verification
Two actions can fall in the same cycle: a clearing write to the status flag, and an overflow that sets the flag. The bench provokes this by issuing a status-clear write on every clock for a stretch that spans a wrap. Its cycle-accurate reference model then expects the flag to read 1 right after the wrapping edge, because the set wins.

The same stretch technique is used for event requests during a run. It also covers divider and period writes that land on an update cycle, where the old written value is what gets transferred.

// File: rtl/upcount_tbase.sv
module upcount_tbase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         uev_o,
  output logic         irq_o,
  output logic         dma_o
);
  localparam logic [W-1:0] TOP_RST = {W{1'b1}};

  logic         run_q, upd_off_q, src_q, buf_q;
  logic         irq_en_q, dma_en_q, flag_q;
  logic [W-1:0] cnt_q, pc_q, div_pre, div_sh, top_pre, top_sh;
  logic         uev_q, dma_q;

  logic sw_req, cnt_wr, tick, ovf, upd_ev, flag_set, flag_clr;

  assign sw_req   = wr_en && addr == 3'd3 && wdata[0];
  assign cnt_wr   = wr_en && addr == 3'd4;
  assign flag_clr = wr_en && addr == 3'd2 && !wdata[0];
  assign tick     = run_q && !sw_req && pc_q == div_sh;
  assign ovf      = tick && !cnt_wr && top_sh != '0 && cnt_q >= top_sh;
  assign upd_ev   = !upd_off_q && (ovf || sw_req);
  assign flag_set = !upd_off_q && (ovf || (sw_req && !src_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (sw_req || tick) begin
      pc_q <= '0;
    end else if (run_q) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sw_req) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      cnt_q <= wdata;
    end else if (ovf) begin
      cnt_q <= '0;
    end else if (tick && top_sh != '0) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_pre <= '0;
      div_sh  <= '0;
      top_pre <= TOP_RST;
      top_sh  <= TOP_RST;
    end else begin
      if (upd_ev) begin
        div_sh <= div_pre;
        top_sh <= top_pre;
      end
      if (wr_en && addr == 3'd5) div_pre <= wdata;
      if (wr_en && addr == 3'd6) begin
        top_pre <= wdata;
        if (!buf_q) top_sh <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      upd_off_q <= 1'b0;
      src_q     <= 1'b0;
      buf_q     <= 1'b0;
      irq_en_q  <= 1'b0;
      dma_en_q  <= 1'b0;
    end else if (wr_en && addr == 3'd0) begin
      run_q     <= wdata[0];
      upd_off_q <= wdata[1];
      src_q     <= wdata[2];
      buf_q     <= wdata[7];
    end else if (wr_en && addr == 3'd1) begin
      irq_en_q  <= wdata[0];
      dma_en_q  <= wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      uev_q  <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      if (flag_set)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      uev_q <= upd_ev;
      dma_q <= flag_set && dma_en_q;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: begin
        rdata[0] = run_q;
        rdata[1] = upd_off_q;
        rdata[2] = src_q;
        rdata[7] = buf_q;
      end
      3'd1: begin
        rdata[0] = irq_en_q;
        rdata[1] = dma_en_q;
      end
      3'd2: rdata[0] = flag_q;
      3'd4: rdata = cnt_q;
      3'd5: rdata = div_pre;
      3'd6: rdata = top_pre;
      default: rdata = '0;
    endcase
  end

  assign uev_o = uev_q;
  assign irq_o = flag_q && irq_en_q;
  assign dma_o = dma_q;
endmodule

// File: rtl/upcount_tbase_chk.sv
module upcount_tbase_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic         wbit0,
  input logic         uev_o,
  input logic         dma_o,
  input logic         flag,
  input logic         upd_off,
  input logic [W-1:0] cnt,
  input logic [W-1:0] top_sh
);
  // R6
  upd_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_off |=> !uev_o);

  // R10
  dma_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_o |-> flag);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_en && addr == 3'd2)) |=> flag);

  // R8
  sw_req_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && wbit0) |=> cnt == '0);

  // R11
  zero_top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_sh == '0 && !(wr_en && (addr == 3'd3 || addr == 3'd4))) |=> $stable(cnt));
endmodule

bind upcount_tbase upcount_tbase_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wbit0(wdata[0]),
  .uev_o(uev_o), .dma_o(dma_o), .flag(flag_q), .upd_off(upd_off_q),
  .cnt(cnt_q), .top_sh(top_sh)
);

// File: tb/tb_upcount_tbase.sv
module tb_upcount_tbase;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0]  addr = 3'd4;
  logic [15:0] wdata = '0, rdata;
  logic        uev_o, irq_o, dma_o;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  upcount_tbase dut (.clk, .rst_n, .wr_en, .addr, .wdata, .rdata, .uev_o, .irq_o, .dma_o);

  int m_cnt, m_pc, m_divp, m_divs, m_topp, m_tops;
  bit m_run, m_off, m_src, m_buf, m_ien, m_den, m_flag, m_uev, m_dma;

  function automatic int m_read(int a);
    case (a)
      0: return m_run | (m_off << 1) | (m_src << 2) | (m_buf << 7);
      1: return m_ien | (m_den << 1);
      2: return m_flag;
      4: return m_cnt;
      5: return m_divp;
      6: return m_topp;
      default: return 0;
    endcase
  endfunction

  task automatic m_reset();
    m_cnt = 0; m_pc = 0; m_divp = 0; m_divs = 0; m_topp = 'hFFFF; m_tops = 'hFFFF;
    {m_run, m_off, m_src, m_buf, m_ien, m_den, m_flag, m_uev, m_dma} = '0;
  endtask

  task automatic m_step(bit we, int a, int d);
    bit sw, cw, tk, ov, ev, fs;
    sw = we && a == 3 && d[0];
    cw = we && a == 4;
    tk = 0;
    if (sw) m_pc = 0;
    else if (m_run) begin
      if (m_pc == m_divs) begin tk = 1; m_pc = 0; end
      else m_pc++;
    end
    ov = tk && !cw && m_tops != 0 && m_cnt >= m_tops;
    if (sw) m_cnt = 0;
    else if (cw) m_cnt = d;
    else if (ov) m_cnt = 0;
    else if (tk && m_tops != 0) m_cnt = (m_cnt + 1) & 'hFFFF;
    ev = !m_off && (ov || sw);
    fs = !m_off && (ov || (sw && !m_src));
    if (ev) begin m_divs = m_divp; m_tops = m_topp; end
    if (we && a == 5) m_divp = d;
    if (we && a == 6) begin m_topp = d; if (!m_buf) m_tops = d; end
    m_uev = ev;
    m_dma = fs && m_den;
    if (fs) m_flag = 1;
    else if (we && a == 2 && !d[0]) m_flag = 0;
    if (we && a == 0) begin m_run = d[0]; m_off = d[1]; m_src = d[2]; m_buf = d[7]; end
    if (we && a == 1) begin m_ien = d[0]; m_den = d[1]; end
  endtask

  task automatic cmp(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    cmp(tag, "rdata", rdata, m_read(addr));
    cmp(tag, "uev_o", uev_o, m_uev);
    cmp(tag, "irq_o", irq_o, m_flag && m_ien);
    cmp(tag, "dma_o", dma_o, m_dma);
  endtask

  task automatic step(bit we, int a, int d, string tag);
    @(negedge clk);
    wr_en = we; addr = 3'(a); wdata = 16'(d);
    @(posedge clk);
    #2;
    m_step(we, a, d);
    compare(tag);
  endtask

  task automatic wr(int a, int d, string tag);
    step(1, a, d, tag);
  endtask

  task automatic idle(int n, int a, string tag);
    for (int i = 0; i < n; i++) step(0, a, 0, tag);
  endtask

  initial begin
    m_reset();
    #20;
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #1;
      compare("R1");
    end
    cmp("R1", "uev_o", uev_o, 0);
    @(negedge clk); rst_n = 1;
    idle(1, 6, "R1");
    // basic run
    wr(6, 5, "R5"); wr(5, 2, "R4"); wr(3, 1, "R8"); idle(1, 3, "R8");
    wr(1, 3, "R10"); wr(0, 1, "R2"); idle(40, 4, "R3");
    idle(5, 2, "R10"); wr(2, 1, "R9"); idle(1, 2, "R9"); wr(2, 0, "R9"); idle(1, 2, "R9");
    // divider change waits for event
    wr(5, 0, "R4"); idle(30, 4, "R4");
    // buffered period
    wr(0, 'h81, "R5"); wr(6, 3, "R5"); idle(30, 4, "R5");
    wr(0, 'h01, "R5"); wr(6, 7, "R5"); idle(20, 4, "R5");
    // request source
    wr(0, 'h05, "R7"); wr(2, 0, "R7"); wr(3, 1, "R7"); idle(2, 2, "R7");
    wr(0, 'h01, "R7"); wr(2, 0, "R7"); wr(3, 1, "R7"); idle(2, 2, "R7");
    // update disable
    wr(0, 'h83, "R6"); wr(6, 2, "R6"); wr(5, 1, "R6"); idle(30, 4, "R6");
    wr(3, 1, "R6"); idle(3, 4, "R6"); wr(0, 'h81, "R6"); idle(30, 4, "R6");
    // clear and set in the same cycle
    for (int i = 0; i < 24; i++) wr(2, 0, "R9");
    for (int i = 0; i < 12; i++) wr(3, 1, "R8");
    wr(5, 3, "R4"); for (int i = 0; i < 20; i++) wr(6, 2 + (i % 3), "R5");
    // zero period and count load
    wr(0, 'h01, "R11"); wr(6, 0, "R11"); idle(12, 4, "R11");
    wr(4, 9, "R12"); idle(8, 4, "R12"); wr(6, 12, "R12"); idle(40, 4, "R12");
    wr(4, 40, "R12"); idle(10, 4, "R3"); wr(1, 1, "R10"); idle(20, 1, "R10");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule